// File: doc/BRIEF.md
# UART Internal Loopback Controller

This block sits between a UART's register write decode, its receive FIFO push port and its modem-status logic. It provides the diagnostic self-test mode. A loopback-enable bit in the control register selects it. While that bit is set, every character software writes for transmission is also offered to the receive FIFO. A rising send-break request is turned into a break word in the receive FIFO. The four modem-control outputs are copied onto the modem-status flags. Characters arriving from the external receive path are thrown away during loopback.

With loopback clear, the external receive path owns the FIFO push port and the modem-status flags track the external modem input pins. The transmit path does not reach the receive FIFO in this mode. The serializer, the FIFO and the pins themselves lie outside the block. One register write is presented per cycle on a small select/data port. All outputs are registered and change one clock after the input that causes them.

The modem-status interrupt bits are recomputed from flag levels, not from edges. Each control write with loopback set replaces all four interrupt bits with the new flag levels. Between such writes, software clears individual bits with a write-one-to-clear mask.

Top module: `uart_loopback`

## Requirements
- R1: After a synchronous reset, rx_push, rx_push_word, rx_overrun, modem_flags, ms_irq and loop_active are all zero, and loopback is off.
- R2: With loopback on, a transmit-data write (wr_sel=0) makes rx_push high on the next cycle, with rx_push_word equal to the written character zero-extended.
- R3: With loopback off, a transmit-data write produces no push. An external character (ext_rx_valid) is pushed on the next cycle with its value zero-extended.
- R4: With loopback on, ext_rx_valid produces no push and no overrun.
- R5: A control write (wr_sel=1) with bit 0 (loopback enable) set sets loop_active. On the next cycle it sets modem_flags as follows: bit 0 (CTS) from data bit 2 (RTS), bit 1 (DSR) from data bit 1 (DTR), bit 2 (DCD) from data bit 3 (OUT1), and bit 3 (RI) from data bit 4 (OUT2). This includes the write that first turns loopback on.
- R6: On such a control write, all four ms_irq bits are replaced by the new modem_flags values. Bits whose flag is low are cleared.
- R7: While loopback is off, modem_flags equals modem_pins one cycle earlier. While loopback is on, modem_pins has no effect on modem_flags.
- R8: A line-control write (wr_sel=2) that raises the send-break bit (data bit 0) from 0 to 1 while loopback is on pushes a word with only bit CHAR_W+2 set (bit 10 at the default width). A write that leaves the bit at 1, clears it, or raises it with loopback off pushes nothing.
- R9: If fifo_full is high in the cycle a push would be made, the character is dropped. rx_push stays low and rx_overrun pulses high for one cycle.
- R10: With no loopback control write in the same cycle, each ms_clr bit set to 1 clears the matching ms_irq bit. A loopback control write in the same cycle takes precedence over ms_clr.
- R11: With ms_clr zero and no loopback control write, ms_irq holds its value. Modem pin changes and a control write that clears loopback do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 transmit data, 1 control, 2 line control, 3 other |
| wr_data | input | CHAR_W | Write data |
| ext_rx_valid | input | 1 | Character arriving from the external receive path |
| ext_rx_data | input | CHAR_W | External received character |
| modem_pins | input | 4 | External modem inputs {RI, DCD, DSR, CTS} |
| ms_clr | input | 4 | Write-one-to-clear mask for ms_irq |
| fifo_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push strobe to the receive FIFO |
| rx_push_word | output | CHAR_W+4 | Word pushed to the receive FIFO |
| rx_overrun | output | 1 | One-cycle pulse when a character is dropped on a full FIFO |
| modem_flags | output | 4 | Modem-status flags {RI, DCD, DSR, CTS} |
| ms_irq | output | 4 | Modem-status interrupt bits, same order |
| loop_active | output | 1 | Loopback mode currently enabled |

## Verification
The bench builds the block with CHAR_W=8. This places the break marker at bit 10 of a 12-bit push word, so a break word can never be mistaken for a full-scale character such as 0xFF. The 8-bit width lets the random phase cover every character value and every control-bit combination, including the upper control bits that must not disturb the flags. fifo_full is driven on its own, which brings overruns into reach on transmit, break and external pushes, in both modes.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

  typedef enum logic [1:0] {
    SEL_TXDATA = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_LINE   = 2'd2,
    SEL_OTHER  = 2'd3
  } wr_sel_e;

  // control-register bit positions
  localparam int CTL_LBE  = 0;
  localparam int CTL_DTR  = 1;
  localparam int CTL_RTS  = 2;
  localparam int CTL_OUT1 = 3;
  localparam int CTL_OUT2 = 4;
  localparam int CTL_W    = 5;

  // line-control bit position
  localparam int LINE_BRK = 0;

  // modem flag / interrupt bit positions
  localparam int MS_CTS = 0;
  localparam int MS_DSR = 1;
  localparam int MS_DCD = 2;
  localparam int MS_RI  = 3;
  localparam int MS_W   = 4;

  // control bit that drives each modem flag in loopback
  function automatic int flag_src(input int idx);
    case (idx)
      MS_CTS:  return CTL_RTS;
      MS_DSR:  return CTL_DTR;
      MS_DCD:  return CTL_OUT1;
      default: return CTL_OUT2;
    endcase
  endfunction

endpackage

// File: rtl/uart_lb_regs.sv
module uart_lb_regs
  import uart_lb_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              lb_on,
  output logic              lb_next,
  output logic              tx_evt,
  output logic              ctrl_lb_wr,
  output logic              brk_rise
);

  wr_sel_e sel;
  logic    ctrl_evt;
  logic    line_evt;
  logic    brk_q;

  always_comb begin
    sel        = wr_sel_e'(wr_sel);
    tx_evt     = wr_en && (sel == SEL_TXDATA);
    ctrl_evt   = wr_en && (sel == SEL_CTRL);
    line_evt   = wr_en && (sel == SEL_LINE);
    lb_next    = ctrl_evt ? wr_data[CTL_LBE] : lb_on;
    ctrl_lb_wr = ctrl_evt && wr_data[CTL_LBE];
    brk_rise   = line_evt && wr_data[LINE_BRK] && !brk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lb_on <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      lb_on <= lb_next;
      if (line_evt) brk_q <= wr_data[LINE_BRK];
    end
  end

endmodule

// File: rtl/uart_lb_route.sv
module uart_lb_route #(
  parameter int CHAR_W  = 8,
  parameter int WORD_W  = CHAR_W + 4,
  parameter int BRK_BIT = CHAR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_on,
  input  logic              tx_evt,
  input  logic              brk_rise,
  input  logic [CHAR_W-1:0] tx_char,
  input  logic              ext_valid,
  input  logic [CHAR_W-1:0] ext_char,
  input  logic              fifo_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic              overrun
);

  localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << BRK_BIT;

  logic              cand;
  logic [WORD_W-1:0] cand_word;

  // loopback owns the push port; external data only when loopback is off
  always_comb begin
    cand      = 1'b0;
    cand_word = '0;
    if (lb_on) begin
      if (tx_evt) begin
        cand      = 1'b1;
        cand_word = WORD_W'(tx_char);
      end else if (brk_rise) begin
        cand      = 1'b1;
        cand_word = BRK_WORD;
      end
    end else if (ext_valid) begin
      cand      = 1'b1;
      cand_word = WORD_W'(ext_char);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      push      <= 1'b0;
      push_word <= '0;
      overrun   <= 1'b0;
    end else begin
      push    <= cand && !fifo_full;
      overrun <= cand && fifo_full;
      if (cand && !fifo_full) push_word <= cand_word;
    end
  end

endmodule

// File: rtl/uart_lb_modem.sv
module uart_lb_modem
  import uart_lb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_lb_wr,
  input  logic             lb_next,
  input  logic [CTL_W-1:0] ctrl_bits,
  input  logic [MS_W-1:0]  pins,
  input  logic [MS_W-1:0]  clr,
  output logic [MS_W-1:0]  flags,
  output logic [MS_W-1:0]  irq
);

  for (genvar i = 0; i < MS_W; i++) begin : g_bit
    localparam int SRC = flag_src(i);

    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        irq[i]   <= 1'b0;
      end else if (ctrl_lb_wr) begin
        // level-based rebuild: the bit ends up equal to the new flag
        flags[i] <= ctrl_bits[SRC];
        irq[i]   <= ctrl_bits[SRC];
      end else begin
        if (!lb_next) flags[i] <= pins[i];
        if (clr[i])   irq[i]   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_loopback.sv
module uart_loopback
  import uart_lb_pkg::*;
#(
  parameter int CHAR_W = 8,
  localparam int WORD_W = CHAR_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              ext_rx_valid,
  input  logic [CHAR_W-1:0] ext_rx_data,
  input  logic [3:0]        modem_pins,
  input  logic [3:0]        ms_clr,
  input  logic              fifo_full,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_push_word,
  output logic              rx_overrun,
  output logic [3:0]        modem_flags,
  output logic [3:0]        ms_irq,
  output logic              loop_active
);

  logic lb_on;
  logic lb_next;
  logic tx_evt;
  logic ctrl_lb_wr;
  logic brk_rise;

  uart_lb_regs #(.CHAR_W(CHAR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .lb_on      (lb_on),
    .lb_next    (lb_next),
    .tx_evt     (tx_evt),
    .ctrl_lb_wr (ctrl_lb_wr),
    .brk_rise   (brk_rise)
  );

  uart_lb_route #(.CHAR_W(CHAR_W)) u_route (
    .clk       (clk),
    .rst       (rst),
    .lb_on     (lb_on),
    .tx_evt    (tx_evt),
    .brk_rise  (brk_rise),
    .tx_char   (wr_data),
    .ext_valid (ext_rx_valid),
    .ext_char  (ext_rx_data),
    .fifo_full (fifo_full),
    .push      (rx_push),
    .push_word (rx_push_word),
    .overrun   (rx_overrun)
  );

  uart_lb_modem u_modem (
    .clk        (clk),
    .rst        (rst),
    .ctrl_lb_wr (ctrl_lb_wr),
    .lb_next    (lb_next),
    .ctrl_bits  (wr_data[CTL_W-1:0]),
    .pins       (modem_pins),
    .clr        (ms_clr),
    .flags      (modem_flags),
    .irq        (ms_irq)
  );

  assign loop_active = lb_on;

endmodule

// File: rtl/uart_lb_checker.sv
module uart_lb_checker
  import uart_lb_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [CHAR_W-1:0] wr_data,
  input logic              ext_rx_valid,
  input logic [3:0]        modem_pins,
  input logic              fifo_full,
  input logic              rx_push,
  input logic [CHAR_W+3:0] rx_push_word,
  input logic              rx_overrun,
  input logic [3:0]        modem_flags,
  input logic [3:0]        ms_irq,
  input logic              lb_on
);

  logic ctrl_lb;
  logic ctrl_any;
  assign ctrl_lb  = wr_en && (wr_sel == 2'd1) && wr_data[CTL_LBE];
  assign ctrl_any = wr_en && (wr_sel == 2'd1);

  assert_tx_loop_R2: assert property (@(posedge clk) disable iff (rst)
    (lb_on && wr_en && wr_sel == 2'd0 && !fifo_full)
      |=> (rx_push && rx_push_word == (CHAR_W+4)'($past(wr_data))));

  assert_ext_block_R4: assert property (@(posedge clk) disable iff (rst)
    (lb_on && ext_rx_valid && !wr_en) |=> (!rx_push && !rx_overrun));

  assert_flag_map_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl_lb |=> (modem_flags == {$past(wr_data[CTL_OUT2]), $past(wr_data[CTL_OUT1]),
                                 $past(wr_data[CTL_DTR]),  $past(wr_data[CTL_RTS])}));

  assert_irq_rebuild_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_lb |=> (ms_irq == modem_flags));

  assert_pins_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (!lb_on && !ctrl_any) |=> (modem_flags == $past(modem_pins)));

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
    fifo_full |=> !rx_push);

  assert_overrun_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rx_push && rx_overrun));

endmodule

bind uart_loopback uart_lb_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .ext_rx_valid (ext_rx_valid),
  .modem_pins   (modem_pins),
  .fifo_full    (fifo_full),
  .rx_push      (rx_push),
  .rx_push_word (rx_push_word),
  .rx_overrun   (rx_overrun),
  .modem_flags  (modem_flags),
  .ms_irq       (ms_irq),
  .lb_on        (lb_on)
);

// File: tb/uart_loopback_bench.sv
module uart_loopback_bench;

  localparam int CHAR_W = 8;
  localparam int WORD_W = CHAR_W + 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = 2'd3;
  logic [CHAR_W-1:0] wr_data = '0;
  logic              ext_rx_valid = 1'b0;
  logic [CHAR_W-1:0] ext_rx_data = '0;
  logic [3:0]        modem_pins = '0;
  logic [3:0]        ms_clr = '0;
  logic              fifo_full = 1'b0;
  logic              rx_push;
  logic [WORD_W-1:0] rx_push_word;
  logic              rx_overrun;
  logic [3:0]        modem_flags;
  logic [3:0]        ms_irq;
  logic              loop_active;

  always #2 clk = ~clk;  // 250 MHz

  uart_loopback #(.CHAR_W(CHAR_W)) u_uart_loopback (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data),
    .modem_pins(modem_pins), .ms_clr(ms_clr), .fifo_full(fifo_full),
    .rx_push(rx_push), .rx_push_word(rx_push_word), .rx_overrun(rx_overrun),
    .modem_flags(modem_flags), .ms_irq(ms_irq), .loop_active(loop_active)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  bit                m_lb, m_brk;
  logic [3:0]        m_flags, m_irq;
  bit                e_push, e_ovr;
  logic [WORD_W-1:0] q_words[$];
  string             push_tag, flag_tag, irq_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lb = 0; m_brk = 0; m_flags = '0; m_irq = '0; e_push = 0; e_ovr = 0;
    q_words.delete();
  endtask

  // one clock of the reference model, from inputs stable across the edge
  task automatic model_step();
    bit cand;
    bit ctrl_w, lb_w, lbn;
    logic [WORD_W-1:0] w;
    cand = 0; w = '0; push_tag = "R3";
    ctrl_w = wr_en && wr_sel == 2'd1;
    lb_w   = ctrl_w && wr_data[0];
    if (m_lb) begin
      push_tag = "R4";
      if (wr_en && wr_sel == 2'd0) begin
        cand = 1; w = WORD_W'(wr_data); push_tag = "R2";
      end else if (wr_en && wr_sel == 2'd2 && wr_data[0] && !m_brk) begin
        cand = 1; w = WORD_W'(1) << (CHAR_W + 2); push_tag = "R8";
      end else if (wr_en && wr_sel == 2'd2) push_tag = "R8";
    end else if (ext_rx_valid) begin
      cand = 1; w = WORD_W'(ext_rx_data);
    end else if (wr_en && wr_sel == 2'd2) push_tag = "R8";
    if (cand && fifo_full) push_tag = "R9";
    e_push = cand && !fifo_full;
    e_ovr  = cand && fifo_full;
    if (e_push) q_words.push_back(w);
    lbn = ctrl_w ? wr_data[0] : m_lb;
    if (lb_w) begin
      m_flags = {wr_data[4], wr_data[3], wr_data[1], wr_data[2]};
      m_irq   = m_flags;
      flag_tag = "R5"; irq_tag = "R6";
    end else begin
      flag_tag = "R7";
      if (!lbn) m_flags = modem_pins;
      irq_tag = (ms_clr != 0) ? "R10" : "R11";
      m_irq = m_irq & ~ms_clr;
    end
    if (wr_en && wr_sel == 2'd2) m_brk = wr_data[0];
    m_lb = lbn;
  endtask

  task automatic compare();
    logic [WORD_W-1:0] ew;
    check(rx_push == e_push, push_tag, "rx_push", rx_push, e_push);
    check(rx_overrun == e_ovr, e_ovr ? "R9" : push_tag, "rx_overrun", rx_overrun, e_ovr);
    if (rx_push && e_push) begin
      ew = q_words.pop_front();
      check(rx_push_word == ew, push_tag, "rx_push_word", rx_push_word, ew);
    end
    check(modem_flags == m_flags, flag_tag, "modem_flags", modem_flags, m_flags);
    check(ms_irq == m_irq, irq_tag, "ms_irq", ms_irq, m_irq);
    check(loop_active == m_lb, "R5", "loop_active", loop_active, m_lb);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    #1;
    compare();
    wr_en = 0; wr_sel = 2'd3; ext_rx_valid = 0; ms_clr = '0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [CHAR_W-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step();
  endtask

  task automatic ext(input logic [CHAR_W-1:0] d);
    ext_rx_valid = 1; ext_rx_data = d;
    step();
  endtask

  initial begin : watchdog
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    model_reset();
    // R1: reset state
    check(rx_push == 0 && rx_overrun == 0 && rx_push_word == 0, "R1", "push outputs",
          {rx_push, rx_overrun, rx_push_word}, 0);
    check(modem_flags == 0 && ms_irq == 0 && loop_active == 0, "R1", "modem outputs",
          {modem_flags, ms_irq, loop_active}, 0);

    // loopback off: pins followed (R7), tx ignored, ext pushed (R3)
    modem_pins = 4'b1010; step();
    wr(2'd0, 8'h41);
    ext(8'h55);
    fifo_full = 1; ext(8'h66); fifo_full = 0;          // R9 on external path
    wr(2'd2, 8'h01);                                    // R8 break without loopback
    wr(2'd2, 8'h00);

    // enter loopback with only the enable bit (R5)
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h1F);                                    // all flags, all irq (R6)
    wr(2'd1, 8'h0B);                                    // R6 clears CTS and RI
    modem_pins = 4'b0101; step(); step();               // R7/R11 pins ignored
    wr(2'd0, 8'hA5);                                    // R2
    wr(2'd0, 8'hFF);
    ext(8'h33);                                         // R4
    wr(2'd2, 8'h01);                                    // R8 break word
    wr(2'd2, 8'h01);                                    // held: no push
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
    fifo_full = 1; wr(2'd0, 8'h77); fifo_full = 0;      // R9
    ms_clr = 4'b0010; step();                           // R10
    wr(2'd1, 8'h1F);
    ms_clr = 4'b1111; wr_en = 1; wr_sel = 2'd1; wr_data = 8'h05; step(); // R10 precedence
    wr(2'd1, 8'h1E);                                    // leave loopback, R11
    step();
    wr(2'd0, 8'h12);                                    // R3

    // random phase
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_en        = lfsr[0] & lfsr[5];
      wr_sel       = lfsr[2:1];
      wr_data      = lfsr[15:8] ^ lfsr[7:0];
      ext_rx_valid = lfsr[3];
      ext_rx_data  = lfsr[11:4];
      modem_pins   = lfsr[9:6];
      ms_clr       = (lfsr[14:12] == 3'd0) ? lfsr[4:1] : 4'd0;
      fifo_full    = (lfsr[15:13] == 3'd7);
      step();
    end
    fifo_full = 0;
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule